// File: doc/BRIEF.md
# Diagonal-Sum Phase Detector with Fault Mute

This block compares the timing of two sliced binary signals: the A+C and the B+D diagonal-sum comparator outputs of an optical pickup. Both are sampled on the channel-bit clock. For each transition it emits a lead or lag pulse whose width is the time between matching transitions on the two inputs. A downstream low-pass filter turns these pulses into a tracking-error voltage. A programmable delay on the B+D path trims the tracking balance. A programmable cap limits the length of any single pulse.

A run-length watchdog watches both inputs. If either one sits at one level for more than 16 channel-bit periods, it raises a fault flag. The flag drops again once that input next changes. While the fault flag is set and fault muting is enabled, the pulse outputs are forced idle. A register bit, an external pin and an interrupt line can also force the outputs idle. Deselecting the block clears all of its state and holds every output low.

Top module: `dpd_phase_mute`

## Requirements
- R1: When an A+C edge comes before the delayed B+D edge, `lead_o` stays high for exactly the number of clocks between the two edges as they reach the core. It first rises two clocks after the A+C edge is presented.
- R2: When the delayed B+D edge comes before an A+C edge, `lag_o` stays high for exactly the number of clocks between them. A lag pulse persists for as long as no A+C edge arrives.
- R3: If the A+C edge and the delayed B+D edge reach the core in the same clock, neither pulse is produced.
- R4: `bal_dly` (0 to 15) delays the B+D input by that many clocks before it is compared with A+C.
- R5: A nonzero `pw_cap` value N limits any lead or lag pulse to N clocks. The value 0 leaves pulses unlimited.
- R6: When fault muting is enabled, `fault_o` rises at the 18th clock edge after an input transition is presented, provided that input has not changed again. At that point the level has been held for 17 sampled periods, which is more than 16.
- R7: `fault_o` falls two clock edges after the held input changes. When `flt_en` is 0, `fault_o` stays 0 and no muting comes from the watchdog.
- R8: While `fault_o` is 1, `lead_o` and `lag_o` are both 0.
- R9: Each of `mute_reg`, `mute_pin` and `irq_in` on its own forces both `lead_o` and `lag_o` to 0 in the same cycle. The pulse reappears once the mute input is released.
- R10: While `dpd_sel` is 0, all outputs are 0 and the internal state is cleared. A pulse in progress does not resume when the block is selected again.
- R11: `lead_o` and `lag_o` are never high together.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel-bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dpd_sel | input | 1 | Tracking-error select: 1 activates the block |
| flt_en | input | 1 | Enables the run-length fault detector and its mute |
| mute_reg | input | 1 | Mute control register bit |
| mute_pin | input | 1 | External mute input |
| irq_in | input | 1 | Interrupt flag, mutes when high |
| bal_dly | input | 4 | Balance delay on the B+D path, in clocks |
| pw_cap | input | 4 | Pulse width cap in clocks, 0 means unlimited |
| ac_in | input | 1 | A+C comparator output |
| bd_in | input | 1 | B+D comparator output |
| lead_o | output | 1 | Lead phase pulse |
| lag_o | output | 1 | Lag phase pulse |
| fault_o | output | 1 | Abnormal-waveform fault flag |

## Verification
The hardest state to reach is a fault raised by one input while the other input keeps changing and a pulse is still active. Only that state shows that the watchdog suppresses a live output, rather than an output that was idle anyway. The stimulus first toggles both inputs together, then starts a lag pulse that never ends by toggling only B+D. It keeps B+D moving every six clocks so that only A+C can trip the 16-period limit. It then checks the clock-exact rise of the fault flag and the muting of the lag pulse, and finally releases the fault with one A+C edge. The pulse behaviour is swept over every balance delay against a grid of edge offsets, each with a different cap.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  localparam int CFG_W     = 4;
  localparam int RUN_LIMIT = 16;

  typedef enum logic [1:0] {
    PD_IDLE = 2'd0,
    PD_LEAD = 2'd1,
    PD_LAG  = 2'd2
  } pd_state_e;
endpackage

// File: rtl/dpd_delay_tap.sv
module dpd_delay_tap #(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CFG_W-1:0] sel,
  input  logic             din,
  output logic             dout
);
  localparam int DEPTH = (1 << CFG_W) - 1;

  logic [DEPTH-1:0] hist_q, hist_d;

  always_comb begin
    hist_d = {hist_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hist_q <= '0;
    else if (!en) hist_q <= '0;
    else          hist_q <= hist_d;
  end

  always_comb begin
    dout = din;
    for (int k = 0; k < DEPTH; k++) begin
      if (sel == CFG_W'(k + 1)) dout = hist_q[k];
    end
  end

  // R4: a one-clock setting reproduces the input of the previous cycle
  assert_one_tap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && sel == CFG_W'(1) && $past(sel) == CFG_W'(1)) |-> dout == $past(din));
endmodule

// File: rtl/dpd_run_mon.sv
module dpd_run_mon #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl,
  output logic flag
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             edge_w;

  assign edge_w = lvl ^ lvl_q;

  always_comb begin
    if (edge_w)                           cnt_d = '0;
    else if (cnt_q == CNT_W'(LIMIT))      cnt_d = cnt_q;
    else                                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl;
      cnt_q <= cnt_d;
    end
  end

  assign flag = (cnt_q == CNT_W'(LIMIT));

  // R6: the flag only rises while the watched level stays put
  assert_rise_on_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $stable(lvl));
  // R7: an edge on the watched level clears a raised flag
  assert_edge_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && flag && edge_w) |=> !flag);
endmodule

// File: rtl/dpd_phase_core.sv
module dpd_phase_core
  import dpd_pkg::*;
#(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             a,
  input  logic             b,
  input  logic [CFG_W-1:0] cap,
  output logic             lead,
  output logic             lag
);
  logic             a_q, b_q, a_edge, b_edge;
  pd_state_e        st_q, st_d;
  logic [CFG_W-1:0] wcnt_q, wcnt_d;
  logic             cap_ok;

  assign a_edge = a ^ a_q;
  assign b_edge = b ^ b_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PD_IDLE: begin
        if (a_edge && !b_edge)      st_d = PD_LEAD;
        else if (b_edge && !a_edge) st_d = PD_LAG;
      end
      PD_LEAD: if (b_edge) st_d = PD_IDLE;
      PD_LAG:  if (a_edge) st_d = PD_IDLE;
      default: st_d = PD_IDLE;
    endcase
  end

  always_comb begin
    if (st_d == PD_IDLE || st_q == PD_IDLE) wcnt_d = '0;
    else if (wcnt_q == '1)                  wcnt_d = wcnt_q;
    else                                    wcnt_d = wcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0; b_q <= 1'b0; st_q <= PD_IDLE; wcnt_q <= '0;
    end else if (!en) begin
      a_q <= 1'b0; b_q <= 1'b0; st_q <= PD_IDLE; wcnt_q <= '0;
    end else begin
      a_q <= a; b_q <= b; st_q <= st_d; wcnt_q <= wcnt_d;
    end
  end

  assign cap_ok = (cap == '0) || (wcnt_q < cap);
  assign lead   = (st_q == PD_LEAD) && cap_ok;
  assign lag    = (st_q == PD_LAG)  && cap_ok;

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead && lag));
  assert_lead_ends_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st_q == PD_LEAD && b_edge) |=> st_q != PD_LEAD);
  assert_off_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> st_q == PD_IDLE);
endmodule

// File: rtl/dpd_phase_mute.sv
module dpd_phase_mute
  import dpd_pkg::*;
#(
  parameter int CFG_W     = dpd_pkg::CFG_W,
  parameter int RUN_LIMIT = dpd_pkg::RUN_LIMIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dpd_sel,
  input  logic             flt_en,
  input  logic             mute_reg,
  input  logic             mute_pin,
  input  logic             irq_in,
  input  logic [CFG_W-1:0] bal_dly,
  input  logic [CFG_W-1:0] pw_cap,
  input  logic             ac_in,
  input  logic             bd_in,
  output logic             lead_o,
  output logic             lag_o,
  output logic             fault_o
);
  localparam int NCH = 2;

  logic       rst_meta_q, rst_sync_q;
  logic       a_r, b_r, b_dly;
  logic [NCH-1:0] lvl_w, flag_w;
  logic       lead_raw, lag_raw, mute_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      a_r <= 1'b0;
      b_r <= 1'b0;
    end else if (!dpd_sel) begin
      a_r <= 1'b0;
      b_r <= 1'b0;
    end else begin
      a_r <= ac_in;
      b_r <= bd_in;
    end
  end

  dpd_delay_tap #(.CFG_W(CFG_W)) bal_i (
    .clk(clk), .rst_n(rst_sync_q), .en(dpd_sel),
    .sel(bal_dly), .din(b_r), .dout(b_dly)
  );

  assign lvl_w = {b_r, a_r};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_runmon
    dpd_run_mon #(.LIMIT(RUN_LIMIT)) mon_i (
      .clk(clk), .rst_n(rst_sync_q), .en(dpd_sel),
      .lvl(lvl_w[ch]), .flag(flag_w[ch])
    );
  end

  dpd_phase_core #(.CFG_W(CFG_W)) core_i (
    .clk(clk), .rst_n(rst_sync_q), .en(dpd_sel),
    .a(a_r), .b(b_dly), .cap(pw_cap),
    .lead(lead_raw), .lag(lag_raw)
  );

  assign fault_o = dpd_sel && flt_en && (|flag_w);
  assign mute_w  = fault_o || mute_reg || mute_pin || irq_in;
  assign lead_o  = dpd_sel && !mute_w && lead_raw;
  assign lag_o   = dpd_sel && !mute_w && lag_raw;
endmodule

// File: tb/dpd_phase_mute_tb.sv
module dpd_phase_mute_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, dpd_sel, flt_en, mute_reg, mute_pin, irq_in;
  logic [3:0] bal_dly, pw_cap;
  logic       ac_in, bd_in;
  logic       lead_o, lag_o, fault_o;
  int         n_chk = 0, n_bad = 0;
  logic       cur_a = 1'b0, cur_b = 1'b0;

  always #10 clk = ~clk;

  dpd_phase_mute dut_i (
    .clk(clk), .rst_n(rst_n), .dpd_sel(dpd_sel), .flt_en(flt_en),
    .mute_reg(mute_reg), .mute_pin(mute_pin), .irq_in(irq_in),
    .bal_dly(bal_dly), .pw_cap(pw_cap), .ac_in(ac_in), .bd_in(bd_in),
    .lead_o(lead_o), .lag_o(lag_o), .fault_o(fault_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dpd_sel = 1'b1; flt_en = 1'b0; mute_reg = 1'b0;
    mute_pin = 1'b0; irq_in = 1'b0; bal_dly = 4'd0; pw_cap = 4'd0;
    ac_in = 1'b0; bd_in = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    check("R12 reset lead", int'(lead_o), 0);
    check("R12 reset lag", int'(lag_o), 0);
    check("R12 reset fault", int'(fault_o), 0);

    // R1 R2 R3 R4 R5: sweep balance delay against edge offsets and caps
    for (int bal = 0; bal < 16; bal++) begin
      for (int ta = 1; ta <= 8; ta++) begin
        for (int tb = 1; tb <= 8; tb++) begin
          int cap, d, wl, wg, nl, ng;
          string tag;
          cap = (ta * 3 + tb + bal) % 16;
          bal_dly = 4'(bal);
          pw_cap = 4'(cap);
          d = tb + bal - ta;
          wl = (d > 0) ? d : 0;
          wg = (d < 0) ? -d : 0;
          if (cap != 0 && wl > cap) wl = cap;
          if (cap != 0 && wg > cap) wg = cap;
          nl = 0; ng = 0;
          for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            nl += int'(lead_o);
            ng += int'(lag_o);
            ac_in = cur_a ^ (i >= ta);
            bd_in = cur_b ^ (i >= tb);
          end
          cur_a = ac_in; cur_b = bd_in;
          tag = (d > 0) ? "R1" : (d < 0) ? "R2" : "R3";
          if (bal != 0) tag = {tag, "/R4"};
          if (cap != 0) tag = {tag, "/R5"};
          check($sformatf("%s lead width bal=%0d ta=%0d tb=%0d cap=%0d", tag, bal, ta, tb, cap), nl, wl);
          check($sformatf("%s lag width bal=%0d ta=%0d tb=%0d cap=%0d", tag, bal, ta, tb, cap), ng, wg);
        end
      end
    end

    // R6 R7 R8: A+C held while B+D keeps moving and a lag pulse is live
    bal_dly = 4'd0; pw_cap = 4'd0; flt_en = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i == 17) begin
        check("R6 fault before limit", int'(fault_o), 0);
        check("R2 lag live before fault", int'(lag_o), 1);
      end
      if (i == 18) begin
        check("R6 fault after 17 held periods", int'(fault_o), 1);
        check("R8 lag muted by fault", int'(lag_o), 0);
        check("R8 lead muted by fault", int'(lead_o), 0);
      end
      if (i == 26) check("R7 fault held one clock after edge", int'(fault_o), 1);
      if (i == 27) check("R7 fault cleared after edge", int'(fault_o), 0);
      if (i == 0) begin cur_a = ~cur_a; cur_b = ~cur_b; end
      if (i == 3 || i == 9 || i == 15 || i == 21) cur_b = ~cur_b;
      if (i == 25) cur_a = ~cur_a;
      ac_in = cur_a; bd_in = cur_b;
    end

    // R9: each mute source alone, with fault detection off
    flt_en = 1'b0;
    tick(5);
    cur_b = ~cur_b; bd_in = cur_b;
    tick(4);
    check("R9 lag present before mute", int'(lag_o), 1);
    for (int s = 0; s < 3; s++) begin
      mute_reg = (s == 0); mute_pin = (s == 1); irq_in = (s == 2);
      tick(1);
      check($sformatf("R9 lag muted by source %0d", s), int'(lag_o), 0);
      check($sformatf("R9 lead idle under source %0d", s), int'(lead_o), 0);
      mute_reg = 1'b0; mute_pin = 1'b0; irq_in = 1'b0;
      tick(1);
      check($sformatf("R9 lag back after source %0d", s), int'(lag_o), 1);
    end

    // R7: long hold with detection disabled
    tick(24);
    check("R7 no fault when disabled", int'(fault_o), 0);
    check("R7 no watchdog mute when disabled", int'(lag_o), 1);

    // R10: deselect clears state
    dpd_sel = 1'b0;
    tick(1);
    check("R10 lag low when deselected", int'(lag_o), 0);
    check("R10 fault low when deselected", int'(fault_o), 0);
    ac_in = 1'b0; bd_in = 1'b0; cur_a = 1'b0; cur_b = 1'b0;
    tick(3);
    dpd_sel = 1'b1;
    tick(4);
    check("R10 lag not resumed", int'(lag_o), 0);
    check("R10 lead idle after reselect", int'(lead_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule